// File: doc/BRIEF.md
# Read Data Reorder Buffer

This block sits between a memory controller's read path and its AXI-style read data channel. A read request is given a slot when it is admitted. The slot holds room for every packet the request was cut into. The read data path then writes DRAM data beats into that slot one beat per cycle, addressed by slot, packet index and beat index. The packets of one request may complete in any order, so the slot tracks which of them are present.

A response can be sent once all of its packets are present and no older admitted request with the same ID is still held. Among the responses that can be sent, a round-robin arbiter picks one. That response then streams out beat by beat in packet order, with last on its final beat. When the last beat is accepted the slot is released and can be handed out again. Because responses wait only on older requests with the same ID, requests with different IDs overtake each other freely.

Top module: `rd_reorder_buf`

## Requirements
- R1: After reset, rsp_valid is 0 and alloc_ready is 1.
- R2: An allocation is taken when alloc_valid and alloc_ready are both 1 in a cycle. alloc_slot names the lowest-numbered free slot. alloc_ready is 0 exactly when all 8 slots are held, and an alloc_valid raised in that state changes nothing.
- R3: A fill beat is stored at (fill_slot, fill_pkt, fill_beat). Fill beat indices 0 and 1 are the two beats of a packet. A packet counts as present when its beat with index 1 is written.
- R4: alloc_pkts_m1 holds the packet count minus one (0 to 3). A response starts only after every packet 0..alloc_pkts_m1 of its slot is present, in whatever order they were filled. rsp_valid rises on the second clock edge after the last missing packet's final beat is written.
- R5: Two responses with the same alloc_id leave in the order their allocations were taken. A younger one that is complete waits for an older one that is not.
- R6: A complete response is not held back by an incomplete older request that has a different ID.
- R7: When several responses can be sent, the winner is the first ready slot at or above the slot after the last one granted, counting upward and wrapping from 7 to 0. After reset the search starts at slot 0.
- R8: A response sends its beats back to back in order: packet 0 beat 0, packet 0 beat 1, packet 1 beat 0, and so on. rsp_last is 1 on the final beat only. While rsp_valid is 1 and rsp_ready is 0, rsp_id, rsp_data and rsp_last hold steady.
- R9: The slot is freed at the clock edge that accepts the last beat, so alloc_ready is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Admit a read request this cycle |
| alloc_id | input | ID_W (4) | AXI ID of the request |
| alloc_pkts_m1 | input | 2 | Number of packets in the request minus one |
| alloc_ready | output | 1 | A free slot exists (free-space indicator) |
| alloc_slot | output | 3 | Slot tag given to the admitted request |
| fill_valid | input | 1 | A DRAM data beat is presented |
| fill_slot | input | 3 | Slot tag of the beat |
| fill_pkt | input | 2 | Packet index within the request |
| fill_beat | input | 1 | Beat index within the packet |
| fill_data | input | DATA_W (32) | Beat data |
| rsp_valid | output | 1 | Response beat available |
| rsp_ready | input | 1 | Consumer takes the beat |
| rsp_id | output | ID_W (4) | ID of the response |
| rsp_data | output | DATA_W (32) | Response beat data |
| rsp_last | output | 1 | Final beat of the response |

## Verification
The checker assumes the read data path writes only to slots that are held, writes each packet of a request once with its beats in index order, and never uses a packet index above the allocated count. It also assumes the consumer may stall at any time. The bench keeps to these rules: it fills only slots it has just been given, writes each packet's two beats on consecutive cycles, and varies packet order and consumer stalls. The ordering checks depend on allocation order, so the bench allocates from an empty buffer and always knows which slot tag each request gets.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    localparam int unsigned RRB_SLOTS_DEF    = 8;
    localparam int unsigned RRB_MAX_PKTS_DEF = 4;
    localparam int unsigned RRB_BEATS_DEF    = 2;
    localparam int unsigned RRB_DATA_W_DEF   = 32;
    localparam int unsigned RRB_ID_W_DEF     = 4;

    // Output streaming state
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } stream_state_e;

    // Index width for n items, never below one bit
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // (a + b) modulo n for a, b < n
    function automatic int unsigned wrap_add(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned n);
        int unsigned s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/rrb_slot_table.sv
module rrb_slot_table
    import rrb_pkg::*;
#(
    parameter  int unsigned SLOTS    = RRB_SLOTS_DEF,
    parameter  int unsigned MAX_PKTS = RRB_MAX_PKTS_DEF,
    parameter  int unsigned ID_W     = RRB_ID_W_DEF,
    localparam int unsigned SLOT_W   = idx_w(SLOTS),
    localparam int unsigned PKT_W    = idx_w(MAX_PKTS)
)(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            alloc_fire,
    input  logic [ID_W-1:0]                 alloc_id,
    input  logic [PKT_W-1:0]                alloc_pkts_m1,
    output logic                            alloc_ready,
    output logic [SLOT_W-1:0]               alloc_slot,
    input  logic                            pkt_done,
    input  logic [SLOT_W-1:0]               done_slot,
    input  logic [PKT_W-1:0]                done_pkt,
    input  logic                            free_fire,
    input  logic [SLOT_W-1:0]               free_slot,
    output logic [SLOTS-1:0]                eligible,
    output logic [SLOTS-1:0][ID_W-1:0]      slot_id,
    output logic [SLOTS-1:0][PKT_W-1:0]     slot_pkts_m1
);

    // Bookkeeping for one held request
    typedef struct packed {
        logic                busy;
        logic [ID_W-1:0]     id;
        logic [PKT_W-1:0]    pkts_m1;
        logic [MAX_PKTS-1:0] done;
        logic [SLOTS-1:0]    deps;   // older same-ID slots still held
    } entry_t;

    logic [SLOTS-1:0] busy_vec;
    logic [SLOTS-1:0] alloc_deps;

    // Lowest free slot wins the allocation
    always_comb begin
        alloc_slot  = '0;
        alloc_ready = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy_vec[i]) begin
                alloc_slot  = SLOT_W'(i);
                alloc_ready = 1'b1;
            end
        end
    end

    // A new request depends on every held slot with the same ID,
    // except one leaving in this very cycle
    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            alloc_deps[j] = busy_vec[j] && (slot_id[j] == alloc_id) &&
                            !(free_fire && (free_slot == SLOT_W'(j)));
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        entry_t              ent_q;
        logic [MAX_PKTS-1:0] need;
        logic                all_here;
        logic                no_elder;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else begin
                if (free_fire) begin
                    ent_q.deps[free_slot] <= 1'b0;
                    if (free_slot == SLOT_W'(i)) ent_q.busy <= 1'b0;
                end
                if (pkt_done && (done_slot == SLOT_W'(i))) begin
                    ent_q.done[done_pkt] <= 1'b1;
                end
                if (alloc_fire && (alloc_slot == SLOT_W'(i))) begin
                    ent_q.busy    <= 1'b1;
                    ent_q.id      <= alloc_id;
                    ent_q.pkts_m1 <= alloc_pkts_m1;
                    ent_q.done    <= '0;
                    ent_q.deps    <= alloc_deps;
                end
            end
        end

        always_comb begin
            for (int p = 0; p < MAX_PKTS; p++) begin
                need[p] = (PKT_W'(p) <= ent_q.pkts_m1);
            end
        end

        assign all_here        = ((need & ~ent_q.done) == '0);
        assign no_elder        = ((ent_q.deps & busy_vec) == '0);
        assign busy_vec[i]     = ent_q.busy;
        assign slot_id[i]      = ent_q.id;
        assign slot_pkts_m1[i] = ent_q.pkts_m1;
        assign eligible[i]     = ent_q.busy && all_here && no_elder;
    end

endmodule

// File: rtl/rrb_beat_store.sv
module rrb_beat_store
    import rrb_pkg::*;
#(
    parameter  int unsigned SLOTS    = RRB_SLOTS_DEF,
    parameter  int unsigned MAX_PKTS = RRB_MAX_PKTS_DEF,
    parameter  int unsigned BEATS    = RRB_BEATS_DEF,
    parameter  int unsigned DATA_W   = RRB_DATA_W_DEF,
    localparam int unsigned SLOT_W   = idx_w(SLOTS),
    localparam int unsigned PKT_W    = idx_w(MAX_PKTS),
    localparam int unsigned BEAT_W   = idx_w(BEATS),
    localparam int unsigned ADDR_W   = SLOT_W + PKT_W + BEAT_W,
    localparam int unsigned DEPTH    = 1 << ADDR_W
)(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [PKT_W-1:0]  wr_pkt,
    input  logic [BEAT_W-1:0] wr_beat,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [PKT_W-1:0]  rd_pkt,
    input  logic [BEAT_W-1:0] rd_beat,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    assign wr_addr = {wr_slot, wr_pkt, wr_beat};
    assign rd_addr = {rd_slot, rd_pkt, rd_beat};

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rrb_rr_arbiter.sv
module rrb_rr_arbiter
    import rrb_pkg::*;
#(
    parameter  int unsigned N     = RRB_SLOTS_DEF,
    localparam int unsigned IDX_W = idx_w(N)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             take,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);

    logic [IDX_W-1:0] ptr_q;

    // First requester at or above the pointer, wrapping
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int unsigned k = 0; k < N; k++) begin
            if (!gnt_valid && req[IDX_W'(wrap_add(32'(ptr_q), k, N))]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(wrap_add(32'(ptr_q), k, N));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (take && gnt_valid) begin
            ptr_q <= IDX_W'(wrap_add(32'(gnt_idx), 1, N));
        end
    end

endmodule

// File: rtl/rd_reorder_buf.sv
module rd_reorder_buf
    import rrb_pkg::*;
#(
    parameter  int unsigned SLOTS    = RRB_SLOTS_DEF,
    parameter  int unsigned MAX_PKTS = RRB_MAX_PKTS_DEF,
    parameter  int unsigned BEATS    = RRB_BEATS_DEF,
    parameter  int unsigned DATA_W   = RRB_DATA_W_DEF,
    parameter  int unsigned ID_W     = RRB_ID_W_DEF,
    localparam int unsigned SLOT_W   = idx_w(SLOTS),
    localparam int unsigned PKT_W    = idx_w(MAX_PKTS),
    localparam int unsigned BEAT_W   = idx_w(BEATS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic [PKT_W-1:0]  alloc_pkts_m1,
    output logic              alloc_ready,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              fill_valid,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [PKT_W-1:0]  fill_pkt,
    input  logic [BEAT_W-1:0] fill_beat,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ID_W-1:0]   rsp_id,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_last
);

    // Position of the beat being streamed
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [PKT_W-1:0]  pkt;
        logic [BEAT_W-1:0] beat;
    } cursor_t;

    stream_state_e               state_q;
    cursor_t                     cur_q;
    logic                        alloc_fire;
    logic                        pkt_done;
    logic                        free_fire;
    logic                        beat_fire;
    logic                        at_last_beat;
    logic                        at_last_pkt;
    logic                        take;
    logic                        gnt_valid;
    logic [SLOT_W-1:0]           gnt_idx;
    logic [SLOTS-1:0]            eligible;
    logic [SLOTS-1:0][ID_W-1:0]  slot_id;
    logic [SLOTS-1:0][PKT_W-1:0] slot_pkts_m1;
    logic [SLOT_W-1:0]           out_slot;

    assign alloc_fire = alloc_valid && alloc_ready;
    assign pkt_done   = fill_valid && (fill_beat == BEAT_W'(BEATS - 1));

    rrb_slot_table #(
        .SLOTS    (SLOTS),
        .MAX_PKTS (MAX_PKTS),
        .ID_W     (ID_W)
    ) u_table (
        .clk           (clk),
        .rst           (rst),
        .alloc_fire    (alloc_fire),
        .alloc_id      (alloc_id),
        .alloc_pkts_m1 (alloc_pkts_m1),
        .alloc_ready   (alloc_ready),
        .alloc_slot    (alloc_slot),
        .pkt_done      (pkt_done),
        .done_slot     (fill_slot),
        .done_pkt      (fill_pkt),
        .free_fire     (free_fire),
        .free_slot     (cur_q.slot),
        .eligible      (eligible),
        .slot_id       (slot_id),
        .slot_pkts_m1  (slot_pkts_m1)
    );

    rrb_beat_store #(
        .SLOTS    (SLOTS),
        .MAX_PKTS (MAX_PKTS),
        .BEATS    (BEATS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (fill_valid),
        .wr_slot (fill_slot),
        .wr_pkt  (fill_pkt),
        .wr_beat (fill_beat),
        .wr_data (fill_data),
        .rd_slot (cur_q.slot),
        .rd_pkt  (cur_q.pkt),
        .rd_beat (cur_q.beat),
        .rd_data (rsp_data)
    );

    rrb_rr_arbiter #(
        .N (SLOTS)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (eligible),
        .take      (take),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    assign take         = (state_q == ST_IDLE) && gnt_valid;
    assign at_last_beat = (cur_q.beat == BEAT_W'(BEATS - 1));
    assign at_last_pkt  = (cur_q.pkt == slot_pkts_m1[cur_q.slot]);
    assign rsp_valid    = (state_q == ST_SEND);
    assign rsp_last     = rsp_valid && at_last_beat && at_last_pkt;
    assign rsp_id       = slot_id[cur_q.slot];
    assign beat_fire    = rsp_valid && rsp_ready;
    assign free_fire    = beat_fire && rsp_last;
    assign out_slot     = cur_q.slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (gnt_valid) begin
                        state_q    <= ST_SEND;
                        cur_q.slot <= gnt_idx;
                        cur_q.pkt  <= '0;
                        cur_q.beat <= '0;
                    end
                end
                ST_SEND: begin
                    if (beat_fire) begin
                        if (rsp_last) begin
                            state_q <= ST_IDLE;
                        end else if (at_last_beat) begin
                            cur_q.beat <= '0;
                            cur_q.pkt  <= cur_q.pkt + 1'b1;
                        end else begin
                            cur_q.beat <= cur_q.beat + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rd_reorder_buf_chk.sv
module rd_reorder_buf_chk
    import rrb_pkg::*;
#(
    parameter  int unsigned SLOTS    = RRB_SLOTS_DEF,
    parameter  int unsigned MAX_PKTS = RRB_MAX_PKTS_DEF,
    parameter  int unsigned BEATS    = RRB_BEATS_DEF,
    parameter  int unsigned DATA_W   = RRB_DATA_W_DEF,
    parameter  int unsigned ID_W     = RRB_ID_W_DEF,
    localparam int unsigned SLOT_W   = idx_w(SLOTS),
    localparam int unsigned PKT_W    = idx_w(MAX_PKTS),
    localparam int unsigned BEAT_W   = idx_w(BEATS)
)(
    input logic              clk,
    input logic              rst,
    input logic              alloc_valid,
    input logic [ID_W-1:0]   alloc_id,
    input logic [PKT_W-1:0]  alloc_pkts_m1,
    input logic              alloc_ready,
    input logic [SLOT_W-1:0] alloc_slot,
    input logic              fill_valid,
    input logic [SLOT_W-1:0] fill_slot,
    input logic [PKT_W-1:0]  fill_pkt,
    input logic [BEAT_W-1:0] fill_beat,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ID_W-1:0]   rsp_id,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_last,
    input logic [SLOT_W-1:0] out_slot
);

    logic [SLOTS-1:0]    c_busy;
    logic [ID_W-1:0]     c_id   [SLOTS];
    logic [PKT_W-1:0]    c_npm1 [SLOTS];
    logic [MAX_PKTS-1:0] c_done [SLOTS];
    logic [31:0]         c_seq  [SLOTS];
    logic [31:0]         seq_ctr;
    logic [SLOT_W:0]     held;
    logic                in_rsp;
    int unsigned         beat_cnt;
    logic                a_fire;
    logic                f_fire;
    logic                starting;

    assign a_fire   = alloc_valid && alloc_ready;
    assign f_fire   = rsp_valid && rsp_ready && rsp_last;
    assign starting = rsp_valid && !in_rsp;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_busy   <= '0;
            seq_ctr  <= '0;
            held     <= '0;
            in_rsp   <= 1'b0;
            beat_cnt <= 0;
            for (int i = 0; i < SLOTS; i++) begin
                c_id[i]   <= '0;
                c_npm1[i] <= '0;
                c_done[i] <= '0;
                c_seq[i]  <= '0;
            end
        end else begin
            AST_FREE_SPACE: assert (alloc_ready == (held != (SLOT_W+1)'(SLOTS)))
                else $error("free-space flag disagrees with held count"); // R2
            if (starting) begin
                for (int p = 0; p < MAX_PKTS; p++) begin
                    if (PKT_W'(p) <= c_npm1[out_slot]) begin
                        AST_ALL_PKTS_IN: assert (c_done[out_slot][p])
                            else $error("response started with a packet missing"); // R4
                    end
                end
                for (int j = 0; j < SLOTS; j++) begin
                    if (SLOT_W'(j) != out_slot) begin
                        AST_SAME_ID_ORDER: assert (!(c_busy[j] && (c_id[j] == rsp_id) &&
                                                     (c_seq[j] < c_seq[out_slot])))
                            else $error("same-ID response overtook an older one"); // R5
                    end
                end
            end
            if (f_fire) begin
                AST_BEAT_TOTAL: assert ((beat_cnt + 1) ==
                                        (32'(c_npm1[out_slot]) + 1) * BEATS)
                    else $error("wrong beat count in response"); // R8
            end

            if (rsp_valid && rsp_ready) begin
                in_rsp   <= !rsp_last;
                beat_cnt <= rsp_last ? 0 : beat_cnt + 1;
            end
            if (f_fire) c_busy[out_slot] <= 1'b0;
            if (fill_valid && (fill_beat == BEAT_W'(BEATS - 1))) begin
                c_done[fill_slot][fill_pkt] <= 1'b1;
            end
            if (a_fire) begin
                c_busy[alloc_slot] <= 1'b1;
                c_id[alloc_slot]   <= alloc_id;
                c_npm1[alloc_slot] <= alloc_pkts_m1;
                c_done[alloc_slot] <= '0;
                c_seq[alloc_slot]  <= seq_ctr;
                seq_ctr            <= seq_ctr + 1;
            end
            held <= held + (a_fire ? 1'b1 : 1'b0) - (f_fire ? 1'b1 : 1'b0);
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                       $stable(rsp_id) && $stable(rsp_last))); // R8

    AST_SLOT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready && rsp_last) |=> alloc_ready); // R9

    AST_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (rst)
        (!rsp_valid && (c_busy == '0)) |=> !rsp_valid); // R4

endmodule

bind rd_reorder_buf rd_reorder_buf_chk #(
    .SLOTS    (SLOTS),
    .MAX_PKTS (MAX_PKTS),
    .BEATS    (BEATS),
    .DATA_W   (DATA_W),
    .ID_W     (ID_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .alloc_valid   (alloc_valid),
    .alloc_id      (alloc_id),
    .alloc_pkts_m1 (alloc_pkts_m1),
    .alloc_ready   (alloc_ready),
    .alloc_slot    (alloc_slot),
    .fill_valid    (fill_valid),
    .fill_slot     (fill_slot),
    .fill_pkt      (fill_pkt),
    .fill_beat     (fill_beat),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_id        (rsp_id),
    .rsp_data      (rsp_data),
    .rsp_last      (rsp_last),
    .out_slot      (out_slot)
);

// File: tb/rd_reorder_buf_bench.sv
module rd_reorder_buf_bench;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ID_W     = 4;
    localparam int unsigned WD_LIMIT = 50000;

    // Vector: {id[3:0], 2'b0, pkts_m1[1:0], fill order as four 2-bit packet indices, first in [1:0]}
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h1000, 16'h2101, 16'h3387, 16'h4212, 16'h53E4, 16'h6104
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              alloc_valid;
    logic [ID_W-1:0]   alloc_id;
    logic [1:0]        alloc_pkts_m1;
    logic              alloc_ready;
    logic [2:0]        alloc_slot;
    logic              fill_valid;
    logic [2:0]        fill_slot;
    logic [1:0]        fill_pkt;
    logic              fill_beat;
    logic [DATA_W-1:0] fill_data;
    logic              rsp_valid;
    logic              rsp_ready;
    logic [ID_W-1:0]   rsp_id;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_last;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [DATA_W-1:0] got [16];
    logic [ID_W-1:0]   got_id;
    int                got_n;
    bit                last_ok;

    rd_reorder_buf u_rd_reorder_buf (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_id(alloc_id), .alloc_pkts_m1(alloc_pkts_m1),
        .alloc_ready(alloc_ready), .alloc_slot(alloc_slot),
        .fill_valid(fill_valid), .fill_slot(fill_slot), .fill_pkt(fill_pkt),
        .fill_beat(fill_beat), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
        .rsp_data(rsp_data), .rsp_last(rsp_last)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            n_bad = n_bad + 1;
            $display("FAIL R4 watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [DATA_W-1:0] beat_val(input logic [7:0] tag, input int p, input int b);
        return {tag, 8'(p), 8'(b), 8'h5A};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [3:0] id, input logic [1:0] npm1,
                            output logic [2:0] slot, output logic rdy);
        alloc_valid   = 1'b1;
        alloc_id      = id;
        alloc_pkts_m1 = npm1;
        #1;
        slot = alloc_slot;
        rdy  = alloc_ready;
        cycle();
        alloc_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [2:0] slot, input int p, input logic [7:0] tag);
        for (int b = 0; b < 2; b++) begin
            fill_valid = 1'b1;
            fill_slot  = slot;
            fill_pkt   = 2'(p);
            fill_beat  = 1'(b);
            fill_data  = beat_val(tag, p, b);
            cycle();
        end
        fill_valid = 1'b0;
    endtask

    task automatic get_rsp();
        int  w;
        bit  done;
        rsp_ready = 1'b1;
        got_n     = 0;
        last_ok   = 1'b1;
        w         = 0;
        while (!rsp_valid && w < 200) begin
            cycle();
            w++;
        end
        if (!rsp_valid) begin
            check(1'b0, "R4 response timeout", 0, 1);
        end else begin
            got_id = rsp_id;
            done   = 1'b0;
            while (!done && got_n < 16) begin
                got[got_n] = rsp_data;
                if (rsp_id != got_id) last_ok = 1'b0;
                done  = rsp_last;
                got_n = got_n + 1;
                cycle();
            end
            if (!done) last_ok = 1'b0;
        end
        rsp_ready = 1'b0;
    endtask

    initial begin
        logic [2:0]  s;
        logic [2:0]  sa;
        logic [2:0]  sb;
        logic        r;
        logic [15:0] mask;
        logic [ID_W-1:0]   h_id;
        logic [DATA_W-1:0] h_data;
        logic              h_last;

        rst = 1'b1;
        alloc_valid = 1'b0; alloc_id = '0; alloc_pkts_m1 = '0;
        fill_valid = 1'b0; fill_slot = '0; fill_pkt = '0; fill_beat = 1'b0; fill_data = '0;
        rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
        check(alloc_ready == 1'b1, "R1 alloc_ready after reset", 32'(alloc_ready), 1);

        // Table walk: fill order permutations, R3 R4 R8
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] vid;
            int         n;
            vid = VEC[v][15:12];
            n   = int'(VEC[v][9:8]) + 1;
            do_alloc(vid, VEC[v][9:8], s, r);
            check(r && s == 3'd0, "R2 slot tag from empty buffer", 32'(s), 0);
            for (int k = 0; k < n; k++) begin
                do_fill(s, int'(VEC[v][2*k +: 2]), 8'(v + 8'h10));
                if (k < n - 1)
                    check(!rsp_valid, "R4 no response with packets missing", 32'(rsp_valid), 0);
            end
            check(!rsp_valid, "R4 response one cycle after last fill", 32'(rsp_valid), 0);
            cycle();
            check(rsp_valid, "R4 response present second edge after fill", 32'(rsp_valid), 1);
            get_rsp();
            check(got_id == vid, "R3 response ID", 32'(got_id), 32'(vid));
            check(got_n == 2 * n && last_ok, "R8 beat count and last", 32'(got_n), 32'(2 * n));
            for (int i = 0; i < got_n && i < 8; i++) begin
                check(got[i] == beat_val(8'(v + 8'h10), i / 2, i % 2),
                      "R3 R8 beat data in packet order", got[i], beat_val(8'(v + 8'h10), i / 2, i % 2));
            end
        end

        // R2 fill all slots, R9 release
        for (int i = 0; i < 8; i++) begin
            do_alloc(4'(i), 2'd0, s, r);
            check(r && s == 3'(i), "R2 lowest free slot", 32'(s), 32'(i));
        end
        check(alloc_ready == 1'b0, "R2 full buffer drops free-space flag", 32'(alloc_ready), 0);
        alloc_valid = 1'b1; alloc_id = 4'hF; alloc_pkts_m1 = 2'd0;
        cycle();
        alloc_valid = 1'b0;
        check(alloc_ready == 1'b0, "R2 allocation while full ignored", 32'(alloc_ready), 0);
        do_fill(3'd3, 0, 8'h33);
        get_rsp();
        check(got_id == 4'd3, "R9 freed response ID", 32'(got_id), 3);
        check(alloc_ready == 1'b1, "R9 free-space after last beat", 32'(alloc_ready), 1);
        do_alloc(4'd9, 2'd0, s, r);
        check(r && s == 3'd3, "R9 released slot reused", 32'(s), 3);
        check(alloc_ready == 1'b0, "R2 full again", 32'(alloc_ready), 0);
        for (int i = 0; i < 8; i++) do_fill(3'(i), 0, 8'(8'h40 + i));
        mask = '0;
        for (int i = 0; i < 8; i++) begin
            get_rsp();
            mask[got_id] = 1'b1;
        end
        check(mask == 16'h02F7, "R2 every admitted ID drained once, none from ignored request", 32'(mask), 32'h02F7);

        // R5 same ID keeps admission order
        do_alloc(4'd5, 2'd0, sa, r);
        do_alloc(4'd5, 2'd0, sb, r);
        do_fill(sb, 0, 8'h21);
        repeat (4) cycle();
        check(!rsp_valid, "R5 younger same-ID waits", 32'(rsp_valid), 0);
        do_fill(sa, 0, 8'h20);
        get_rsp();
        check(got[0] == beat_val(8'h20, 0, 0), "R5 older same-ID first", got[0], beat_val(8'h20, 0, 0));
        get_rsp();
        check(got[0] == beat_val(8'h21, 0, 0), "R5 younger same-ID second", got[0], beat_val(8'h21, 0, 0));

        // R6 different IDs may pass
        do_alloc(4'd6, 2'd0, sa, r);
        do_alloc(4'd7, 2'd1, sb, r);
        do_fill(sb, 1, 8'h31);
        do_fill(sb, 0, 8'h31);
        get_rsp();
        check(got_id == 4'd7, "R6 younger different-ID overtakes", 32'(got_id), 7);
        do_fill(sa, 0, 8'h30);
        get_rsp();
        check(got_id == 4'd6, "R6 older request follows", 32'(got_id), 6);

        // R7 round robin and R8 stall hold
        do_alloc(4'd1, 2'd0, s, r);
        check(s == 3'd0, "R7 setup slot 0", 32'(s), 0);
        do_alloc(4'd2, 2'd0, s, r);
        do_alloc(4'd3, 2'd0, s, r);
        check(s == 3'd2, "R7 setup slot 2", 32'(s), 2);
        do_fill(3'd1, 0, 8'h51);
        repeat (2) cycle();
        h_id = rsp_id; h_data = rsp_data; h_last = rsp_last;
        check(rsp_valid && h_id == 4'd2, "R8 stalled response shown", 32'(h_id), 2);
        do_fill(3'd0, 0, 8'h50);
        do_fill(3'd2, 0, 8'h52);
        check(rsp_valid && rsp_id == h_id && rsp_data == h_data && rsp_last == h_last,
              "R8 outputs hold under stall", rsp_data, h_data);
        get_rsp();
        check(got_id == 4'd2, "R7 first grant", 32'(got_id), 2);
        get_rsp();
        check(got_id == 4'd3, "R7 rotation after slot 1 picks slot 2", 32'(got_id), 3);
        get_rsp();
        check(got_id == 4'd1, "R7 wrap to slot 0", 32'(got_id), 1);
        check(alloc_ready && !rsp_valid, "R9 buffer empty at end", 32'(alloc_ready), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule